// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time-of-Day Counter

This block keeps a 64-bit time-of-day value in nanoseconds, clocked from a reference clock. A 32-bit phase accumulator receives a programmable addend on every enabled reference cycle. The time value moves forward by a programmable nominal period only in the cycles where that accumulator overflows. Software trims the clock rate by rewriting the addend. Scaling the addend by a few parts per billion changes how often overflows happen, so it also changes the average rate at which time moves forward.

Software reaches the block through a small word-addressed register port. That port holds a control word with the period field, the enable bit and a self-clearing soft-reset bit. It also holds the addend, a read-only view of the accumulator, and the time value split into a low and a high word. Two shadow registers keep 64-bit transfers coherent. Reading the low word freezes the high word for the read that follows. A written low word waits until the high word is written, and then both halves load together. The current time is also driven continuously on a 64-bit output for neighbouring units.

Top module: `tod_clock_top`

## Requirements
- R1: After the asynchronous reset, the time output, the accumulator, the addend, the control word and both shadow registers are all zero.
- R2: In every cycle where the enable bit is set, the accumulator (read at address 2) is replaced by (accumulator + addend) mod 2^32. Writes to address 2 have no effect.
- R3: The time value increases by the period field exactly in the cycles where that 32-bit addition carries out of bit 31. In every other cycle it holds its value.
- R4: While the enable bit is clear, the time value and the accumulator keep their values.
- R5: The control word is at address 0. Bits 25:16 hold the period and bit 2 holds the enable. A read of the control word returns only those fields, and every other bit reads as zero.
- R6: A write to the low time word (address 3) only fills a shadow and leaves the time unchanged. A write to the high time word (address 4) loads {written data, shadow} into the time on the next cycle, and this load wins over any advance in the same cycle.
- R7: A read of address 3 returns the low 32 bits of the current time and captures the high 32 bits into a shadow. A read of address 4 returns that shadow.
- R8: A control write with bit 5 set clears the time, the accumulator and both shadows on the next cycle. Period and enable are taken from the same write, and bit 5 always reads back as zero.
- R9: The time output always equals the internal time value, so a coherent 64-bit read through addresses 3 then 4 matches it.
- R10: The addend is read and written at address 1, and a new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is active |
| time_o | output | 64 | Current time in nanoseconds |

## Verification
On every cycle, the embedded properties check the following: the accumulator and time freeze while the timer is disabled, time moves only on a carry or a load, a high-word write loads the exact shadow pair, soft reset clears the counters and shadows, and the high shadow captures on every low-word read. Only the bench scenarios can show the long-run behaviour. That means the count of overflows over many cycles of a given addend, the resulting time for random addends trimmed by a ppb value, carries across the 32-bit word boundary, and the fact that a stale high shadow is returned after the time has been rewritten.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL   = 3'd0,
    SEL_ADDEND = 3'd1,
    SEL_ACCUM  = 3'd2,
    SEL_TLO    = 3'd3,
    SEL_THI    = 3'd4
  } reg_sel_e;

  // decoded bus events, one cycle wide
  typedef struct packed {
    logic soft_rst;
    logic load_hi;
    logic rd_lo;
    logic wr_lo;
    logic wr_ctrl;
    logic wr_add;
  } bus_evt_t;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int PER_W    = 10,
  parameter int PER_LSB  = 16,
  parameter int EN_BIT   = 2,
  parameter int SRST_BIT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BUS_W-1:0]     wdata,
  output logic [BUS_W-1:0]     rdata,
  input  logic [2*BUS_W-1:0]   cnt_i,
  input  logic [BUS_W-1:0]     acc_i,
  output logic [PER_W-1:0]     period_o,
  output logic                 enable_o,
  output logic [BUS_W-1:0]     addend_o,
  output logic                 srst_o,
  output logic                 load_o,
  output logic [2*BUS_W-1:0]   load_val_o
);
  localparam int TIME_W = 2 * BUS_W;

  bus_evt_t           evt;
  logic [PER_W-1:0]   period_q;
  logic               enable_q;
  logic [BUS_W-1:0]   addend_q;
  logic [BUS_W-1:0]   lo_shadow;
  logic [BUS_W-1:0]   hi_shadow;

  function automatic logic [BUS_W-1:0] pack_ctrl(input logic [PER_W-1:0] per,
                                                 input logic en);
    logic [BUS_W-1:0] w;
    w = '0;
    w[PER_LSB +: PER_W] = per;
    w[EN_BIT] = en;
    return w;
  endfunction

  always_comb begin
    evt.wr_ctrl  = wr_en && (addr == SEL_CTRL);
    evt.wr_add   = wr_en && (addr == SEL_ADDEND);
    evt.wr_lo    = wr_en && (addr == SEL_TLO);
    evt.load_hi  = wr_en && (addr == SEL_THI);
    evt.rd_lo    = rd_en && (addr == SEL_TLO);
    evt.soft_rst = wr_en && (addr == SEL_CTRL) && wdata[SRST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      enable_q <= 1'b0;
      addend_q <= '0;
    end else begin
      if (evt.wr_ctrl) begin
        period_q <= wdata[PER_LSB +: PER_W];
        enable_q <= wdata[EN_BIT];
      end
      if (evt.wr_add) addend_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_shadow <= '0;
      hi_shadow <= '0;
    end else if (evt.soft_rst) begin
      lo_shadow <= '0;
      hi_shadow <= '0;
    end else begin
      if (evt.wr_lo) lo_shadow <= wdata;
      if (evt.rd_lo) hi_shadow <= cnt_i[TIME_W-1:BUS_W];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        SEL_CTRL:   rdata = pack_ctrl(period_q, enable_q);
        SEL_ADDEND: rdata = addend_q;
        SEL_ACCUM:  rdata = acc_i;
        SEL_TLO:    rdata = cnt_i[BUS_W-1:0];
        SEL_THI:    rdata = hi_shadow;
        default:    rdata = '0;
      endcase
    end
  end

  assign period_o   = period_q;
  assign enable_o   = enable_q;
  assign addend_o   = addend_q;
  assign srst_o     = evt.soft_rst;
  assign load_o     = evt.load_hi;
  assign load_val_o = {wdata, lo_shadow};

  p_hi_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rd_lo |=> hi_shadow == $past(cnt_i[TIME_W-1:BUS_W]));

  p_shadow_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt.soft_rst |=> (lo_shadow == '0) && (hi_shadow == '0));

  p_ctrl_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.wr_ctrl |=> $stable(period_q) && $stable(enable_q));

  p_lo_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.wr_lo && !evt.soft_rst |=> $stable(lo_shadow));
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             carry_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  function automatic logic [ACC_W:0] acc_sum(input logic [ACC_W-1:0] a,
                                             input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum = acc_sum(acc_q, addend_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= sum[ACC_W-1:0];
  end

  assign acc_o   = acc_q;
  assign carry_o = en_i && !clr_i && sum[ACC_W];

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i && !clr_i |=> $stable(acc_q));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> acc_q == '0);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !clr_i |=> acc_q == ACC_W'($past(acc_q) + $past(addend_i)));
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int TIME_W = 64,
  parameter int PER_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic [PER_W-1:0]  period_i,
  output logic [TIME_W-1:0] cnt_o
);
  logic [TIME_W-1:0] cnt_q;

  function automatic logic [TIME_W-1:0] advance(input logic [TIME_W-1:0] t,
                                                input logic [PER_W-1:0] p);
    return t + TIME_W'(p);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (step_i)  cnt_q <= advance(cnt_q, period_i);
  end

  assign cnt_o = cnt_q;

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i && !load_i && !step_i |=> $stable(cnt_q));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !clr_i && !load_i |=> cnt_q == $past(cnt_q) + TIME_W'($past(period_i)));

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !clr_i |=> cnt_q == $past(load_val_i));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/tod_clock_top.sv
module tod_clock_top
  import tod_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int PER_W    = 10,
  parameter int PER_LSB  = 16,
  parameter int EN_BIT   = 2,
  parameter int SRST_BIT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [2*BUS_W-1:0]   time_o
);
  localparam int TIME_W = 2 * BUS_W;

  logic [PER_W-1:0]  period;
  logic              enable;
  logic [BUS_W-1:0]  addend;
  logic              soft_rst;
  logic              load_hi;
  logic [TIME_W-1:0] load_val;
  logic [BUS_W-1:0]  acc;
  logic              carry;
  logic [TIME_W-1:0] cnt;

  tod_regs #(
    .BUS_W(BUS_W), .PER_W(PER_W), .PER_LSB(PER_LSB),
    .EN_BIT(EN_BIT), .SRST_BIT(SRST_BIT)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .cnt_i(cnt), .acc_i(acc),
    .period_o(period), .enable_o(enable), .addend_o(addend),
    .srst_o(soft_rst), .load_o(load_hi), .load_val_o(load_val)
  );

  tod_accum #(.ACC_W(BUS_W)) accum_i (
    .clk(clk), .rst_n(rst_n),
    .en_i(enable), .clr_i(soft_rst), .addend_i(addend),
    .acc_o(acc), .carry_o(carry)
  );

  tod_counter #(.TIME_W(TIME_W), .PER_W(PER_W)) counter_i (
    .clk(clk), .rst_n(rst_n),
    .clr_i(soft_rst), .load_i(load_hi), .load_val_i(load_val),
    .step_i(carry), .period_i(period), .cnt_o(cnt)
  );

  assign time_o = cnt;

  p_no_step_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !load_hi && !soft_rst |=> $stable(time_o));
endmodule

// File: tb/tod_clock_top_tb_top.sv
module tod_clock_top_tb_top;
  localparam logic [2:0] A_CTRL = 3'd0, A_ADD = 3'd1, A_ACC = 3'd2, A_LO = 3'd3, A_HI = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr, rd;
  logic [2:0]  addr;
  logic [31:0] wdata;
  wire  [31:0] rdata;
  wire  [63:0] tod;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_time;
  logic [31:0] m_acc;

  always #4 clk = ~clk;

  tod_clock_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .time_o(tod)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // all bus tasks start and end at a falling edge, spanning one rising edge
  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0; addr = '0;
  endtask

  function automatic logic [31:0] ctrl_word(input int per, input bit en, input bit sr);
    return (32'(per) << 16) | (en ? 32'd4 : 32'd0) | (sr ? 32'd32 : 32'd0);
  endfunction

  function automatic logic [63:0] total_sum(input logic [31:0] acc0, input logic [31:0] a, input int n);
    return {32'd0, acc0} + 64'(a) * 64'(n);
  endfunction

  function automatic logic [31:0] trim(input logic [31:0] base, input int ppb);
    logic [63:0] d;
    int mag;
    mag = (ppb < 0) ? -ppb : ppb;
    d = (64'(base) * 64'(mag)) / 64'd1000000000;
    return (ppb < 0) ? base - d[31:0] : base + d[31:0];
  endfunction

  // enable for k idle cycles: k+1 accumulating edges in total
  task automatic run(input int per, input int k, input logic [31:0] a);
    logic [63:0] t;
    bus_wr(A_CTRL, ctrl_word(per, 1, 0));
    repeat (k) @(negedge clk);
    bus_wr(A_CTRL, ctrl_word(per, 0, 0));
    t = total_sum(m_acc, a, k + 1);
    m_time = m_time + (t >> 32) * 64'(per);
    m_acc  = t[31:0];
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    bus_rd(A_LO, lo);
    bus_rd(A_HI, hi);
    t = {hi, lo};
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t;
    logic [31:0] a;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; wr = 0; rd = 0; addr = 0; wdata = 0;
    m_time = '0; m_acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 time", tod, 64'd0);
    bus_rd(A_CTRL, d); chk("R1 ctrl", 64'(d), 64'd0);
    bus_rd(A_ADD, d);  chk("R1 addend", 64'(d), 64'd0);
    bus_rd(A_ACC, d);  chk("R1 accum", 64'(d), 64'd0);
    bus_rd(A_HI, d);   chk("R1 hi shadow", 64'(d), 64'd0);

    // R5 field positions, other bits read zero (bit 5 clear here)
    bus_wr(A_CTRL, 32'hFFFF_FFDF);
    bus_rd(A_CTRL, d); chk("R5 ctrl readback", 64'(d), 64'h03FF_0004);
    bus_wr(A_CTRL, 32'd0);
    chk("R4 zero addend no move", tod, 64'd0);

    // R10 addend, R2/R3 half-rate carries
    bus_wr(A_ADD, 32'h8000_0000);
    bus_rd(A_ADD, d); chk("R10 addend readback", 64'(d), 64'h8000_0000);
    run(8, 9, 32'h8000_0000);
    chk("R3 time after 10 cycles", tod, m_time);
    chk("R3 expected 40", m_time, 64'd40);
    bus_rd(A_ACC, d); chk("R2 accum", 64'(d), 64'(m_acc));

    // R4 hold while disabled
    repeat (20) @(negedge clk);
    chk("R4 time hold", tod, m_time);
    bus_rd(A_ACC, d); chk("R4 accum hold", 64'(d), 64'(m_acc));

    // R2 write to accumulator address ignored
    bus_wr(A_ACC, 32'h1234_5678);
    bus_rd(A_ACC, d); chk("R2 accum write ignored", 64'(d), 64'(m_acc));

    // R6 low write shadowed, high write loads
    bus_wr(A_LO, 32'hFFFF_FFF8);
    chk("R6 low write no effect", tod, m_time);
    bus_wr(A_HI, 32'd5);
    m_time = 64'h5_FFFF_FFF8;
    chk("R6 load pair", tod, m_time);

    // R7 high shadow captured at low read
    bus_rd(A_LO, d); chk("R7 low read", 64'(d), 64'hFFFF_FFF8);
    bus_wr(A_LO, 32'd0);
    bus_wr(A_HI, 32'd9);
    bus_rd(A_HI, d); chk("R7 stale shadow", 64'(d), 64'd5);
    read_time(t); chk("R9 coherent read", t, 64'h9_0000_0000);

    // R3 carry across word boundary
    bus_wr(A_LO, 32'hFFFF_FFF8);
    bus_wr(A_HI, 32'd5);
    m_time = 64'h5_FFFF_FFF8;
    bus_wr(A_ADD, 32'hFFFF_FFFF);
    run(16, 3, 32'hFFFF_FFFF);
    chk("R3 word carry", tod, 64'h6_0000_0028);
    read_time(t); chk("R9 read matches", t, tod);
    bus_rd(A_ACC, d); chk("R2 accum wrap", 64'(d), 64'hFFFF_FFFC);

    // R6 load wins over a same-cycle advance
    bus_wr(A_LO, 32'h100);
    bus_wr(A_CTRL, ctrl_word(16, 1, 0));
    bus_wr(A_HI, 32'd7);
    chk("R6 load priority", tod, 64'h7_0000_0100);
    bus_wr(A_CTRL, ctrl_word(16, 0, 0));

    // R8 soft reset clears time, accum and shadows
    bus_wr(A_LO, 32'hABCD);
    bus_rd(A_LO, d);
    bus_wr(A_CTRL, ctrl_word(8, 0, 1));
    chk("R8 time cleared", tod, 64'd0);
    bus_rd(A_ACC, d);  chk("R8 accum cleared", 64'(d), 64'd0);
    bus_rd(A_HI, d);   chk("R8 hi shadow cleared", 64'(d), 64'd0);
    bus_rd(A_CTRL, d); chk("R8 ctrl after reset", 64'(d), 64'h0008_0000);
    bus_wr(A_HI, 32'd3);
    chk("R8 lo shadow cleared", tod, 64'h3_0000_0000);

    // random addends trimmed by ppb, random periods and start times
    for (int i = 0; i < 24; i++) begin
      int per, k, ppb;
      logic [31:0] lo, hi;
      per = $urandom_range(1, 1023);
      k   = $urandom_range(0, 60);
      ppb = int'($urandom_range(0, 1000000)) - 500000;
      a   = trim($urandom, ppb);
      lo  = $urandom;
      hi  = $urandom;
      bus_wr(A_CTRL, ctrl_word(per, 0, 1));
      m_acc = '0;
      bus_wr(A_ADD, a);
      bus_wr(A_LO, lo);
      bus_wr(A_HI, hi);
      m_time = {hi, lo};
      run(per, k, a);
      chk("R3 random time", tod, m_time);
      bus_rd(A_ACC, d); chk("R2 random accum", 64'(d), 64'(m_acc));
      read_time(t); chk("R9 random read", t, m_time);
    end

    done = 1;
    report();
  end
endmodule